// File: doc/BRIEF.md
# Bit-Serial Second-Order Recursive Filter

This block computes the recursion y(n) = x(n) - (7/8)·y(n-1) + (1/2)·y(n-2) on fractional two's complement samples of W bits. Each sample enters one bit per clock on `xBit`, least significant bit first. A one-cycle `wordStart` pulse travels with bit 0 of every input word. The filtered sample leaves on `yOut` in the same bit order. `yValid` marks the clock in which `yOut` carries the sign bit of a finished output word.

The recursion is evaluated in two serial steps. The first step forms the feedback part w(n) from the delayed outputs. The second step adds the new input to w(n). The coefficients are fixed, so the logic needs no multiplier. The -7/8 term is built as the negated previous output plus that output scaled down by eight. The 1/2 term is the output from two samples back, scaled down by two. Each scaling is a choice of tap on the bit-level delay line, with the sign bit repeated for the upper bit positions. The delay line holds past outputs, and each feedback path through it contains exactly W bit delays per word-level delay.

Words may follow back to back, or with idle cycles between them. While no word is in flight, the filter state is frozen.

Top module: `bsiir_top`

## Requirements
- R1: Each output word equals, modulo 2^W, the integer x - y1 + floor(y1/8) + floor(y2/2). All values are W-bit two's complement integers in LSB units. y1 and y2 are the two previous output words. The scaled terms are truncated toward minus infinity.
- R2: Serial ports carry bit k of a word in the k-th clock counted from the `wordStart` pulse (k = 0 .. W-1), LSB first. Output bit k appears on `yOut` one clock after input bit k is sampled.
- R3: `yValid` is high for exactly one clock per input word. That clock is the one after the input's last bit (bit W-1) is sampled, and it is the clock in which `yOut` carries the output sign bit.
- R4: The feedback holds exactly one past word per word-level delay. An impulse of 0.5 (code 0x40 for W = 8) followed by zeros yields the recursion's impulse response over 24 samples.
- R5: While reset (`rstN` low) is active, `yOut` and `yValid` are 0. After reset the past outputs read as zero.
- R6: Sums that leave the W-bit range wrap around in two's complement, with no saturation.
- R7: Idle cycles between words, with `wordStart` low after a word's last bit, do not change any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wordStart | input | 1 | High in the clock of bit 0 of an input word |
| xBit | input | 1 | Serial input sample, LSB first |
| yOut | output | 1 | Serial output sample, LSB first |
| yValid | output | 1 | High while `yOut` carries the sign bit of an output word |

## Verification
The input is sampled on the rising edge that closes clock k of a word, and output bit k is registered on that same edge. The bench therefore reads `yOut` at the following falling edge, and it rebuilds each output word by shifting in one bit per falling edge. `yValid` is due at the falling edge that follows the edge sampling input bit W-1. At that moment the shift register holds the complete word, so the word is compared there against the next entry in a queue of model results. The bench also checks that a valid pulse never lasts two samples, and that the number of pulses matches the number of words sent.

// File: rtl/bsiir_pkg.sv
package bsiir_pkg;

  // Strobes from the bit sequencer to the serial datapath
  typedef struct packed {
    logic run;       // a word is in flight, shift the delay line
    logic firstBit;  // bit 0: seed adder carries
    logic latch1;    // capture sign of y(n-1) from the /8 tap
    logic useHeld1;  // feed repeated sign of y(n-1) into the /8 term
    logic latch2;    // capture sign of y(n-2) from the /2 tap
    logic useHeld2;  // feed repeated sign of y(n-2) into the /2 term
    logic lastBit;   // bit W-1: sign position
  } ctrlStrobes_t;

endpackage

// File: rtl/bsiir_serial_add.sv
// One-bit serial adder or subtractor with a registered carry.
// SUB = 1 computes a - b by inverting b and seeding the carry with 1.
module bsiir_serial_add #(
  parameter bit SUB = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic firstBit,
  input  logic aBit,
  input  logic bBit,
  output logic sumBit
);

  logic carryReg;
  logic carryIn;
  logic bEff;

  assign bEff    = SUB ? ~bBit : bBit;
  assign carryIn = firstBit ? SUB : carryReg;
  assign sumBit  = aBit ^ bEff ^ carryIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryReg <= 1'b0;
    end else if (enable) begin
      carryReg <= (aBit & bEff) | (aBit & carryIn) | (bEff & carryIn);
    end
  end

endmodule

// File: rtl/bsiir_ctrl.sv
// Bit sequencer: tracks the bit index of the word in flight and issues strobes.
module bsiir_ctrl
  import bsiir_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wordStart,
  output ctrlStrobes_t ctl,
  output logic         yValid
);

  localparam int CW        = $clog2(W + 1);
  localparam logic [CW-1:0] IDLE_IDX = CW'(W);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);
  localparam logic [CW-1:0] SIGN1_IDX = CW'(W - 4);
  localparam logic [CW-1:0] SIGN2_IDX = CW'(W - 2);

  logic [CW-1:0] bitIdxReg;
  logic [CW-1:0] bitNow;

  assign bitNow = wordStart ? '0 : bitIdxReg;

  always_comb begin
    ctl          = '0;
    ctl.run      = (bitNow != IDLE_IDX);
    ctl.firstBit = (bitNow == '0);
    ctl.latch1   = (bitNow == SIGN1_IDX);
    ctl.useHeld1 = ctl.run && (bitNow > SIGN1_IDX);
    ctl.latch2   = (bitNow == SIGN2_IDX);
    ctl.useHeld2 = (bitNow == LAST_IDX);
    ctl.lastBit  = (bitNow == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdxReg <= IDLE_IDX;
      yValid    <= 1'b0;
    end else begin
      yValid <= ctl.lastBit;
      if (!ctl.run || ctl.lastBit) begin
        bitIdxReg <= IDLE_IDX;
      end else begin
        bitIdxReg <= bitNow + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bsiir_datapath.sv
// Serial datapath: output delay line, scaled taps and three serial adders.
module bsiir_datapath
  import bsiir_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t ctl,
  input  logic         xBit,
  output logic         yOut
);

  // Two word-level delays = 2W bit delays; the first is the output register.
  localparam int LINE_LEN = 2 * W;
  localparam int TAP_Y1   = W - 1;      // bit k of y(n-1)
  localparam int TAP_SH1  = W - 4;      // bit k+3 of y(n-1): scale by 1/8
  localparam int TAP_SH2  = 2 * W - 2;  // bit k+1 of y(n-2): scale by 1/2

  logic [LINE_LEN-2:0] line;
  logic held1;
  logic held2;
  logic y1ShOp;
  logic y2ShOp;
  logic diffBit;
  logic wBit;
  logic yBit;

  assign y1ShOp = ctl.useHeld1 ? held1 : line[TAP_SH1];
  assign y2ShOp = ctl.useHeld2 ? held2 : line[TAP_SH2];

  // y2/2 - y1
  bsiir_serial_add #(.SUB(1'b1)) u_sub (
    .clk(clk), .rstN(rstN), .enable(ctl.run), .firstBit(ctl.firstBit),
    .aBit(y2ShOp), .bBit(line[TAP_Y1]), .sumBit(diffBit)
  );

  // w = (y2/2 - y1) + y1/8
  bsiir_serial_add #(.SUB(1'b0)) u_addW (
    .clk(clk), .rstN(rstN), .enable(ctl.run), .firstBit(ctl.firstBit),
    .aBit(diffBit), .bBit(y1ShOp), .sumBit(wBit)
  );

  // y = w + x
  bsiir_serial_add #(.SUB(1'b0)) u_addX (
    .clk(clk), .rstN(rstN), .enable(ctl.run), .firstBit(ctl.firstBit),
    .aBit(wBit), .bBit(xBit), .sumBit(yBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      line  <= '0;
      held1 <= 1'b0;
      held2 <= 1'b0;
    end else if (ctl.run) begin
      line <= {line[LINE_LEN-3:0], yBit};
      if (ctl.latch1) held1 <= line[TAP_SH1];
      if (ctl.latch2) held2 <= line[TAP_SH2];
    end
  end

  assign yOut = line[0];

endmodule

// File: rtl/bsiir_top.sv
module bsiir_top #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wordStart,
  input  logic xBit,
  output logic yOut,
  output logic yValid
);

  bsiir_pkg::ctrlStrobes_t ctl;

  bsiir_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordStart(wordStart), .ctl(ctl), .yValid(yValid)
  );

  bsiir_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .xBit(xBit), .yOut(yOut)
  );

endmodule

// File: rtl/bsiir_checker.sv
module bsiir_checker #(
  parameter int W = 8
) (
  input logic clk,
  input logic rstN,
  input logic wordStart,
  input logic yOut,
  input logic yValid,
  input logic lastBit,
  input logic useHeld1,
  input logic shOp1
);

  int sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= 0;
    else if (wordStart) sinceStart <= 1;
    else if (sinceStart != 0 && sinceStart <= W) sinceStart <= sinceStart + 1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R5: assert (yOut == 1'b0 && yValid == 1'b0)
        else $error("outputs not cleared during reset");
    end
  end

  // R3: valid lands W clocks after the word start
  assert_valid_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    yValid == (sinceStart == W));

  // R3: single-clock pulse
  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    yValid |=> !yValid);

  // R2: sequencer marks the sign position at bit W-1 of the word
  assert_last_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceStart >= 1 && sinceStart <= W) |-> (lastBit == (sinceStart == W - 1)));

  // R1: repeated sign of y(n-1) stays fixed over the upper positions
  assert_sign_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (useHeld1 && $past(useHeld1)) |-> $stable(shOp1));

endmodule

bind bsiir_top bsiir_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .wordStart(wordStart), .yOut(yOut), .yValid(yValid),
  .lastBit(ctl.lastBit), .useHeld1(ctl.useHeld1), .shOp1(u_dp.y1ShOp)
);

// File: tb/bsiir_top_bench.sv
module bsiir_top_bench;

  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic wordStart = 1'b0;
  logic xBit = 1'b0;
  logic yOut;
  logic yValid;

  int checks = 0;
  int fails = 0;
  int wordsSent = 0;
  int validSeen = 0;
  logic signed [W-1:0] my1 = '0;
  logic signed [W-1:0] my2 = '0;
  logic [W-1:0] expQ[$];
  string tagQ[$];
  logic [W-1:0] acc = '0;
  logic prevValid = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsiir_top #(.W(W)) u_bsiir_top (
    .clk(clk), .rstN(rstN), .wordStart(wordStart), .xBit(xBit),
    .yOut(yOut), .yValid(yValid)
  );

  function automatic logic [W-1:0] modelY(logic signed [W-1:0] x,
                                          logic signed [W-1:0] y1,
                                          logic signed [W-1:0] y2);
    int s;
    s = int'(x) - int'(y1) + (int'(y1) >>> 3) + (int'(y2) >>> 1);
    return s[W-1:0];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(logic [W-1:0] x, string tag, int gap);
    logic [W-1:0] e;
    e = modelY(x, my1, my2);
    my2 = my1;
    my1 = e;
    expQ.push_back(e);
    tagQ.push_back(tag);
    wordsSent++;
    for (int k = 0; k < W; k++) begin
      wordStart = (k == 0);
      xBit = x[k];
      @(posedge clk); #1;
    end
    wordStart = 1'b0;
    xBit = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    wordStart = 1'b0;
    xBit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(yOut == 1'b0 && yValid == 1'b0, "R5 reset outputs", {yOut, yValid}, 0);
    #1 rstN = 1'b1;
    my1 = '0;
    my2 = '0;
    @(posedge clk); #1;
  endtask

  // Monitor: output bit k is readable at the falling edge after it is registered
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      acc = {yOut, acc[W-1:1]};
      if (yValid) begin
        validSeen++;
        check(!prevValid, "R3 single-clock valid", 1, 0);
        if (expQ.size() == 0) begin
          check(0, "R3 valid with no word in flight", acc, 0);
        end else begin
          logic [W-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(acc == e, t, acc, e);
        end
      end
      prevValid = yValid;
    end else begin
      prevValid = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    doReset();

    // R4 / R1: impulse response over 24 samples
    sendWord(8'h40, "R4 impulse", 0);
    for (int i = 0; i < 23; i++) sendWord(8'h00, "R4 impulse tail", 0);

    // R6: sums beyond the range wrap
    for (int i = 0; i < 6; i++) sendWord(8'h7F, "R6 wrap positive", 0);
    for (int i = 0; i < 6; i++) sendWord(8'h80, "R6 wrap negative", 0);

    // R7: idle gaps between words
    for (int i = 0; i < 10; i++) sendWord(W'($urandom), "R7 gapped words", 1 + ($urandom % 5));

    // R5: reset mid-stream clears the history
    repeat (2) @(posedge clk);
    #1;
    doReset();
    sendWord(8'h00, "R5 zero after reset", 0);
    sendWord(8'h00, "R5 zero after reset", 0);

    // R1 / R2: random words, back to back and gapped
    for (int i = 0; i < 150; i++) begin
      sendWord(W'($urandom), "R1 random word", (($urandom % 4) == 0) ? 2 : 0);
    end

    repeat (4) begin @(posedge clk); #1; end
    @(negedge clk); #1;
    check(validSeen == wordsSent, "R3 one valid per word", validSeen, wordsSent);
    check(expQ.size() == 0, "R2 all words returned", expQ.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule